// File: doc/BRIEF.md
# Supply-Fail Write-Protect Sequencer

This block is the control state machine of a battery-backed static memory. It takes three digitised supply-comparator flags and drives the memory's protection and power-source controls. The flags say whether the supply is above the switchover level, above the write-protect trip point, and above the full-function level. Two threshold sets are provided for the trip and full-function flags, one for a narrow-tolerance supply variant and one for a wide-tolerance variant. A select input picks which set is used. The switchover flag is shared by both variants.

Each flag is resynchronised through two flops. It then has to hold a new value for `HOLD` clocks before the state machine sees the change. The machine has four states: sealed, normal, protected on external supply, and on backup cell. In every state except normal, writes are blocked, memory inputs are ignored and data outputs are tri-stated. The backup cell is selected only in the backup state. A part leaves the factory sealed, with the cell isolated, and stays sealed until the supply first climbs above the trip point. A sticky output reports that the seal has been released, and only reset clears it.

Top module: `pwr_guard_seq`

## Requirements
- R1: After reset: `wr_block`=1, `dout_hiz`=1, `in_ignore`=1, `src_batt`=0 and `seal_released`=0.
- R2: While the seal has not been released, `src_batt` stays 0 for any supply level, including levels below the switchover level.
- R3: `seal_released` becomes 1 when the filtered trip flag is first seen high. It then stays 1 until the next reset, whatever the supply does.
- R4: Protection is lifted (`wr_block`=`dout_hiz`=`in_ignore`=0, `src_batt`=0) only once the filtered full-function flag is high.
- R5: From normal operation, a filtered trip flag going low, with the switchover flag still high, sets all three protect outputs to 1 and keeps `src_batt`=0.
- R6: Once the seal has been released, a filtered switchover flag going low sets `src_batt`=1, with all three protect outputs at 1.
- R7: From backup, a filtered switchover flag going high sets `src_batt`=0 and keeps protection on until the full-function flag is high.
- R8: Hysteresis on recovery: a supply above the trip point but below the full-function level keeps protection on after a trip. A supply in that band does not cause a trip from normal operation.
- R9: A level change on a flag input reaches the outputs exactly 3+`HOLD` rising edges later. A flag change that lasts fewer than `HOLD` clocks has no effect on the outputs.
- R10: With `variant_sel`=0 the sequencer uses bit 0 of `trip_ok` and `full_ok`; with `variant_sel`=1 it uses bit 1.
- R11: `src_batt`=1 is never asserted without `wr_block`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, enters the sealed state |
| variant_sel | input | 1 | Threshold set select: 0 narrow tolerance, 1 wide tolerance |
| trip_ok | input | 2 | Supply above trip point, one bit per variant |
| full_ok | input | 2 | Supply above full-function level, one bit per variant |
| swo_ok | input | 1 | Supply above the backup switchover level |
| wr_block | output | 1 | Memory writes blocked |
| dout_hiz | output | 1 | Memory data outputs tri-stated |
| in_ignore | output | 1 | Memory inputs treated as don't-care |
| src_batt | output | 1 | 1 selects the backup cell, 0 the external supply |
| seal_released | output | 1 | Sticky: backup cell armed since the last reset |

## Verification
A flag change takes two synchroniser edges. The change must then persist for `HOLD` edges in the filter, and the state register adds one more edge, so every output moves on edge 3+`HOLD` after the input change. The directed latency check samples on the falling edge after edge 2+`HOLD`, where the old value is expected. It samples again after edge 3+`HOLD`, where the new value is expected. The random and ramp phases hold each supply level for 20 clocks, well beyond that latency, before they compare the outputs. The expected values come from a bench reference model of the settled state, and glitch tests hold a level for fewer than `HOLD` clocks.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_SEALED  = 2'd0,
    ST_NORMAL  = 2'd1,
    ST_PROT    = 2'd2,
    ST_BACKUP  = 2'd3
  } pg_state_e;

  localparam int NFLAG = 3;
  localparam int F_TRIP = 0;
  localparam int F_FULL = 1;
  localparam int F_SWO  = 2;

  function automatic pg_state_e pg_next(input pg_state_e cur, input logic trip,
                                        input logic full, input logic swo);
    pg_state_e n;
    n = cur;
    case (cur)
      ST_SEALED: if (full) n = ST_NORMAL; else if (trip) n = ST_PROT;
      ST_NORMAL: if (!swo) n = ST_BACKUP; else if (!trip) n = ST_PROT;
      ST_PROT:   if (!swo) n = ST_BACKUP; else if (full) n = ST_NORMAL;
      ST_BACKUP: if (swo) n = ST_PROT;
      default:   n = ST_SEALED;
    endcase
    return n;
  endfunction

  function automatic logic pg_protect(input pg_state_e s);
    return s != ST_NORMAL;
  endfunction

  function automatic logic pg_on_cell(input pg_state_e s);
    return s == ST_BACKUP;
  endfunction
endpackage

// File: rtl/pg_flag_filter.sv
module pg_flag_filter #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;
  logic differs;

  assign differs = (s2 != filt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      filt <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (!differs) begin
        cnt <= '0;
      end else if (cnt == CW'(HOLD - 1)) begin
        filt <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // filtered value only ever takes the synchronised value it replaced
  assert_filt_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> (filt == $past(s2)));
  // a change needs the synchronised input to disagree in the cycle before
  assert_filt_needs_diff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> $past(differs));
endmodule

// File: rtl/pg_state_ctl.sv
module pg_state_ctl
  import pwr_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      trip_f,
  input  logic      full_f,
  input  logic      swo_f,
  output pg_state_e state,
  output logic      released
);
  pg_state_e nxt;

  always_comb nxt = pg_next(state, trip_f, full_f, swo_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SEALED;
      released <= 1'b0;
    end else begin
      state    <= nxt;
      released <= released | (nxt != ST_SEALED);
    end
  end

  assert_cell_sealed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !released |-> (state != ST_BACKUP));
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    released |=> released);
  assert_resume_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |-> $past(full_f));
  assert_cell_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BACKUP && $past(state) != ST_BACKUP) |-> !$past(swo_f));
endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
  import pwr_guard_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       variant_sel,
  input  logic [1:0] trip_ok,
  input  logic [1:0] full_ok,
  input  logic       swo_ok,
  output logic       wr_block,
  output logic       dout_hiz,
  output logic       in_ignore,
  output logic       src_batt,
  output logic       seal_released
);
  logic [NFLAG-1:0] raw_flags;
  logic [NFLAG-1:0] filt_flags;
  pg_state_e        state;
  logic             protect;

  always_comb begin
    raw_flags         = '0;
    raw_flags[F_TRIP] = trip_ok[variant_sel];
    raw_flags[F_FULL] = full_ok[variant_sel];
    raw_flags[F_SWO]  = swo_ok;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_filt
    pg_flag_filter #(.HOLD(HOLD)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_flags[i]),
      .filt (filt_flags[i])
    );
  end

  pg_state_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_f  (filt_flags[F_TRIP]),
    .full_f  (filt_flags[F_FULL]),
    .swo_f   (filt_flags[F_SWO]),
    .state   (state),
    .released(seal_released)
  );

  assign protect   = pg_protect(state);
  assign wr_block  = protect;
  assign dout_hiz  = protect;
  assign in_ignore = protect;
  assign src_batt  = pg_on_cell(state);

  assert_batt_protect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_batt |-> wr_block);
  assert_sealed_no_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seal_released |-> !src_batt);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (wr_block && !src_batt && !seal_released));
endmodule

// File: tb/sim_pwr_guard_seq.sv
module sim_pwr_guard_seq;
  localparam int HOLD = 4;
  localparam int SWO_MV = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic variant_sel = 1'b0;
  logic [1:0] trip_ok = '0;
  logic [1:0] full_ok = '0;
  logic swo_ok = 1'b0;
  logic wr_block, dout_hiz, in_ignore, src_batt, seal_released;

  int checks = 0;
  int failures = 0;
  int mv = 0;
  bit done = 0;

  // model state: 0 sealed, 1 normal, 2 protected on external, 3 on cell
  int mstate = 0;
  bit mrel = 0;

  always #5 clk = ~clk;

  pwr_guard_seq #(.HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel),
    .trip_ok(trip_ok), .full_ok(full_ok), .swo_ok(swo_ok),
    .wr_block(wr_block), .dout_hiz(dout_hiz), .in_ignore(in_ignore),
    .src_batt(src_batt), .seal_released(seal_released)
  );

  function automatic int trip_mv(input bit v);
    return v ? 4370 : 4620;
  endfunction
  function automatic int full_mv(input bit v);
    return v ? 4500 : 4750;
  endfunction

  function automatic int model_step(input int s, input bit t, input bit f, input bit w);
    if (s == 0) return f ? 1 : (t ? 2 : 0);
    if (s == 1) return !w ? 3 : (!t ? 2 : 1);
    if (s == 2) return !w ? 3 : (f ? 1 : 2);
    return w ? 2 : 3;
  endfunction

  task automatic drive(input int level);
    mv = level;
    trip_ok[0] = level > trip_mv(1'b0);
    trip_ok[1] = level > trip_mv(1'b1);
    full_ok[0] = level > full_mv(1'b0);
    full_ok[1] = level > full_mv(1'b1);
    swo_ok     = level > SWO_MV;
  endtask

  task automatic settle_model();
    for (int k = 0; k < 3; k++) begin
      mstate = model_step(mstate, mv > trip_mv(variant_sel),
                          mv > full_mv(variant_sel), mv > SWO_MV);
      if (mstate != 0) mrel = 1;
    end
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d (level %0d mV)", req, got, exp, mv);
    end
  endtask

  task automatic chk_outs(input string req, input bit prot, input bit batt, input bit rel);
    chk(req, {wr_block, dout_hiz, in_ignore}, prot ? 7 : 0);
    chk(req, src_batt, batt);
    chk(req, seal_released, rel);
  endtask

  task automatic chk_model(input string req);
    chk_outs(req, mstate != 1, mstate == 3, mrel);
  endtask

  task automatic hold_level(input int level, input int cyc);
    drive(level);
    repeat (cyc) @(posedge clk);
    @(negedge clk);
    settle_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drive(0);
    repeat (3) @(negedge clk);
    chk_outs("R1 in reset", 1, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_outs("R1 after reset", 1, 0, 0);

    hold_level(2500, 20);
    chk_outs("R2 sealed below switchover", 1, 0, 0);
    hold_level(4000, 20);
    chk_outs("R2 sealed mid band", 1, 0, 0);

    // glitch above trip shorter than HOLD: ignored
    drive(4700);
    repeat (HOLD - 1) @(posedge clk);
    @(negedge clk);
    hold_level(4000, 20);
    chk_outs("R9 short glitch ignored", 1, 0, 0);

    // latency of a rising trip flag
    drive(4700);
    repeat (2 + HOLD) @(posedge clk);
    @(negedge clk);
    chk("R9 before due edge", seal_released, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 R3 on due edge", seal_released, 1);
    settle_model();
    chk_outs("R8 trip band keeps protection", 1, 0, 1);

    hold_level(5000, 20);
    chk_outs("R4 normal above full", 0, 0, 1);
    hold_level(4700, 20);
    chk_outs("R8 no trip inside band", 0, 0, 1);
    hold_level(4500, 20);
    chk_outs("R5 protected on external", 1, 0, 1);
    hold_level(4700, 20);
    chk_outs("R8 recovery needs full", 1, 0, 1);
    hold_level(2000, 20);
    chk_outs("R6 on cell", 1, 1, 1);
    hold_level(3500, 20);
    chk_outs("R7 back on external", 1, 0, 1);
    hold_level(5000, 20);
    chk_outs("R4 resume", 0, 0, 1);

    variant_sel = 1'b1;
    hold_level(4550, 20);
    chk_outs("R10 wide variant normal", 0, 0, 1);
    hold_level(4400, 20);
    chk_outs("R10 wide variant band", 0, 0, 1);
    variant_sel = 1'b0;
    hold_level(4550, 20);
    chk_outs("R10 narrow variant trips", 1, 0, 1);

    // reset clears seal
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mstate = 0; mrel = 0;
    hold_level(1000, 20);
    chk_outs("R3 R2 reset reseals", 1, 0, 0);

    // random ramps with a fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 200; n++) begin
      int lv;
      if (($urandom % 8) == 0) variant_sel = ~variant_sel;
      lv = 1500 + int'($urandom % 4000);
      hold_level(lv, 20);
      chk_model("R11 R6 random ramp");
      if (src_batt && !wr_block) chk("R11 cell implies block", 0, 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule